// File: doc/BRIEF.md
# Serial Drive-LED Frame Transmitter

This block sends the LED states of a row of drive bays over a three-wire serial link: a shift clock, a load strobe that marks the start of each frame, and a data-out line. A fourth line, data-in, is sampled once per bit, and the bits from one frame are handed out together when that frame ends. Each frame has one group of three bits for each of four slots. The three bits are activity, locate and fail, sent in that order. A slot map chooses which physical drive's LED bits go into each slot. The frame length can be set. A frame shorter than twelve bits drops the later bits. A longer frame pads the extra bits with zeros.

Frames run back to back for as long as the link is enabled. A divider sets the length of each half of the serial clock in system cycles. The clock, the load strobe and the data line can each be inverted. Load and data can each be moved so that they change at the falling clock edge in the middle of a bit. Data-in can be sampled in either half of a bit. The block marks the first and last system cycle of every frame with a one-cycle pulse. Blink generators elsewhere use these pulses to line up with the frame.

A sequencer state machine has three states. ST_IDLE means the link is disabled. ST_HIGH is the first half of a bit, with the logical clock high. ST_LOW is the second half, with the logical clock low. The transitions are:
- "start": ST_IDLE to ST_HIGH when the link is enabled.
- "mid-bit": ST_HIGH to ST_LOW when the half-period count expires.
- "next-bit": ST_LOW to ST_HIGH for the following bit.
- "wrap": ST_LOW to ST_HIGH on the last bit, which restarts at bit 0 and begins a new frame.
- "abort": any state to ST_IDLE when the enable is cleared.

The frame contents, length and divider are latched on "start" and on "wrap".

Top module: `ledlink_tx`

## Requirements
- R1: Frame bit 3*s+j carries slot s's LED bit j, with j=0 activity, j=1 locate and j=2 fail. Drive d's bits are drive_leds[3*d+j]. Frame bits 12 and above are 0.
- R2: A frame has frame_len_m1+1 bits, from bit 0 upward.
- R3: slot_map[8*s+7:8*s] gives the drive index for slot s. An index of NUM_DRIVES (8) or more sends zeros for that slot.
- R4: Each bit lasts 2*(clk_div+1) system cycles. The logical clock is high for the first clk_div+1 cycles and low for the rest. Frames follow each other with no gap.
- R5: The logical load strobe is high during bit 0 of each frame and low otherwise.
- R6: While link_en is 0, the three output lines sit at their inactive level (logical 0, then the inversion is applied), and no frame pulses appear. Enabling the link starts a new frame at bit 0 on the next cycle.
- R7: inv_sclk, inv_load and inv_dout invert ser_clk, ser_load and ser_dout.
- R8: With load_late or dout_late set, that line changes at the mid-bit falling edge, half a bit later than normal. In the first half of the first bit after enable, it shows 0.
- R9: sd_in is sampled in the first system cycle of a bit's high half when din_early=1, or of its low half when din_early=0. Bit k goes to position k, for k<12.
- R10: rx_bits takes the sampled bits at the end of each frame and shows them from the first cycle of the next frame. Positions past the frame length read 0.
- R11: frame_start is high for exactly the first system cycle of each frame, and frame_end for exactly the last.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en | input | 1 | Link enable |
| clk_div | input | 20 | Half-period length minus one, in system cycles |
| frame_len_m1 | input | 6 | Frame bit count minus one |
| inv_sclk | input | 1 | Invert serial clock |
| inv_load | input | 1 | Invert load strobe |
| inv_dout | input | 1 | Invert data-out |
| load_late | input | 1 | Launch load on the mid-bit falling edge |
| dout_late | input | 1 | Launch data-out on the mid-bit falling edge |
| din_early | input | 1 | Sample data-in in the high half (else the low half) |
| slot_map | input | 32 | Four byte-wide drive indices, one per slot |
| drive_leds | input | 24 | Activity/locate/fail bits of eight drives |
| sd_in | input | 1 | Serial data-in |
| ser_clk | output | 1 | Serial clock |
| ser_load | output | 1 | Load strobe |
| ser_dout | output | 1 | Serial data-out |
| frame_start | output | 1 | First-cycle-of-frame pulse |
| frame_end | output | 1 | Last-cycle-of-frame pulse |
| rx_bits | output | 12 | Data-in bits of the last full frame |

## Verification
Two things can happen on the same clock edge: sampling the last bit of a frame, and copying the collected bits into rx_bits at the end of that frame. This happens when the divider is 0 and data-in is sampled in the low half. The low half is then a single cycle, so it is both the sampling cycle and the frame's last cycle. The bench runs a twelve-bit frame in exactly this setup, with a one in the final data-in position. It then checks that this bit shows up in rx_bits in the first cycle of the next frame, alongside the other eleven. Every output is also compared, cycle by cycle, against an arithmetic model built from the divider and the frame length, across five configurations.

// File: rtl/ledlink_pkg.sv
package ledlink_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } link_state_t;
endpackage

// File: rtl/ledlink_frame_build.sv
module ledlink_frame_build #(
    parameter int NUM_DRIVES = 8,
    parameter int NUM_SLOTS  = 4,
    parameter int LED_BITS   = 3,
    parameter int MAP_W      = 8,
    parameter int MAX_BITS   = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_now,
    input  logic [NUM_SLOTS*MAP_W-1:0]      slot_map,
    input  logic [NUM_DRIVES*LED_BITS-1:0]  drive_leds,
    output logic [MAX_BITS-1:0]             frame_q
);
    localparam int USED_BITS = NUM_SLOTS * LED_BITS;

    logic [USED_BITS-1:0] slot_bits;
    logic [MAX_BITS-1:0]  frame_d;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [MAP_W-1:0]    pick;
        logic [LED_BITS-1:0] grp;
        assign pick = slot_map[s*MAP_W +: MAP_W];
        always_comb begin
            grp = '0;
            for (int d = 0; d < NUM_DRIVES; d++) begin
                if (pick == MAP_W'(d)) grp = drive_leds[d*LED_BITS +: LED_BITS];
            end
        end
        assign slot_bits[s*LED_BITS +: LED_BITS] = grp;
    end

    always_comb begin
        frame_d = '0;
        frame_d[USED_BITS-1:0] = slot_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        frame_q <= '0;
        else if (load_now) frame_q <= frame_d;
    end
endmodule

// File: rtl/ledlink_seq.sv
module ledlink_seq
    import ledlink_pkg::*;
#(
    parameter int DIV_W = 20,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic [LEN_W-1:0] len_m1,
    output link_state_t      state,
    output logic [LEN_W-1:0] idx,
    output logic             phase_first,
    output logic             half_flip,
    output logic             start_evt,
    output logic             frame_last,
    output logic             frame_begin
);
    link_state_t      state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d, div_q;
    logic [LEN_W-1:0] idx_q, idx_d, len_q;
    logic             begin_q;
    logic             half_done;

    assign half_done = (cnt_q == div_q);

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        idx_d     = idx_q;
        start_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d   = ST_HIGH;
                    cnt_d     = '0;
                    idx_d     = '0;
                    start_evt = 1'b1;
                end
            end
            ST_HIGH: begin
                if (half_done) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LOW: begin
                if (half_done) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    if (idx_q == len_q) begin
                        idx_d     = '0;
                        start_evt = 1'b1;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en) begin
            state_d   = ST_IDLE;
            cnt_d     = '0;
            idx_d     = '0;
            start_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            div_q   <= '0;
            begin_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            begin_q <= start_evt;
            if (start_evt) begin
                len_q <= len_m1;
                div_q <= div;
            end
        end
    end

    always_comb begin
        state       = state_q;
        idx         = idx_q;
        frame_begin = begin_q;
        phase_first = (state_q != ST_IDLE) && (cnt_q == '0);
        half_flip   = en && (state_q == ST_HIGH) && half_done;
        frame_last  = en && (state_q == ST_LOW) && half_done && (idx_q == len_q);
    end

    // R6
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE));
    // R4
    half_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_HIGH && half_done) |=> (state_q == ST_LOW || state_q == ST_IDLE));
    // R2
    idx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (idx_q <= len_q));
    // R11
    wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> begin_q);
    // R11
    pulse_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(begin_q && frame_last));
endmodule

// File: rtl/ledlink_pins.sv
module ledlink_pins #(
    parameter int MAX_BITS = 64,
    parameter int LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                active,
    input  logic                clk_hi,
    input  logic                half_flip,
    input  logic [MAX_BITS-1:0] frame_q,
    input  logic [LEN_W-1:0]    idx,
    input  logic                inv_sclk,
    input  logic                inv_load,
    input  logic                inv_dout,
    input  logic                load_late,
    input  logic                dout_late,
    output logic                ser_clk,
    output logic                ser_load,
    output logic                ser_dout
);
    logic bit_now, first_now;
    logic dout_late_q, load_late_q;
    logic ld_log, do_log;

    assign bit_now   = frame_q[idx];
    assign first_now = (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_late_q <= 1'b0;
            load_late_q <= 1'b0;
        end else if (!active) begin
            dout_late_q <= 1'b0;
            load_late_q <= 1'b0;
        end else if (half_flip) begin
            dout_late_q <= bit_now;
            load_late_q <= first_now;
        end
    end

    always_comb begin
        ld_log   = load_late ? load_late_q : first_now;
        do_log   = dout_late ? dout_late_q : bit_now;
        ser_clk  = inv_sclk ^ (en & clk_hi);
        ser_load = inv_load ^ (en & active & ld_log);
        ser_dout = inv_dout ^ (en & active & do_log);
    end

    // R8
    late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !half_flip && $past(active)) |=> $stable(dout_late_q));
endmodule

// File: rtl/ledlink_rx.sv
module ledlink_rx #(
    parameter int RX_W  = 12,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             phase_first,
    input  logic             clk_hi,
    input  logic             din_early,
    input  logic [LEN_W-1:0] idx,
    input  logic             sd_in,
    input  logic             frame_last,
    output logic [RX_W-1:0]  rx_bits
);
    logic [RX_W-1:0] acc_q, acc_d, rx_q;
    logic            sample_now;

    assign sample_now = active && phase_first && (din_early ? clk_hi : !clk_hi);

    always_comb begin
        acc_d = acc_q;
        if (sample_now) begin
            for (int i = 0; i < RX_W; i++) begin
                if (idx == LEN_W'(i)) acc_d[i] = sd_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            rx_q  <= '0;
        end else if (!active) begin
            acc_q <= '0;
        end else if (frame_last) begin
            rx_q  <= acc_d;
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign rx_bits = rx_q;

    // R10
    rx_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_q) |-> $past(frame_last));
endmodule

// File: rtl/ledlink_tx.sv
module ledlink_tx
    import ledlink_pkg::*;
#(
    parameter int NUM_DRIVES = 8,
    parameter int NUM_SLOTS  = 4,
    parameter int LED_BITS   = 3,
    parameter int MAP_W      = 8,
    parameter int DIV_W      = 20,
    parameter int LEN_W      = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            link_en,
    input  logic [DIV_W-1:0]                clk_div,
    input  logic [LEN_W-1:0]                frame_len_m1,
    input  logic                            inv_sclk,
    input  logic                            inv_load,
    input  logic                            inv_dout,
    input  logic                            load_late,
    input  logic                            dout_late,
    input  logic                            din_early,
    input  logic [NUM_SLOTS*MAP_W-1:0]      slot_map,
    input  logic [NUM_DRIVES*LED_BITS-1:0]  drive_leds,
    input  logic                            sd_in,
    output logic                            ser_clk,
    output logic                            ser_load,
    output logic                            ser_dout,
    output logic                            frame_start,
    output logic                            frame_end,
    output logic [NUM_SLOTS*LED_BITS-1:0]   rx_bits
);
    localparam int MAX_BITS = 2 ** LEN_W;
    localparam int RX_W     = NUM_SLOTS * LED_BITS;

    link_state_t         state;
    logic [LEN_W-1:0]    idx;
    logic                phase_first, half_flip, start_evt, frame_last, frame_begin;
    logic                active, clk_hi;
    logic [MAX_BITS-1:0] frame_q;

    assign active = (state != ST_IDLE);
    assign clk_hi = (state == ST_HIGH);

    ledlink_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(link_en), .div(clk_div), .len_m1(frame_len_m1),
        .state(state), .idx(idx), .phase_first(phase_first), .half_flip(half_flip),
        .start_evt(start_evt), .frame_last(frame_last), .frame_begin(frame_begin)
    );

    ledlink_frame_build #(
        .NUM_DRIVES(NUM_DRIVES), .NUM_SLOTS(NUM_SLOTS), .LED_BITS(LED_BITS),
        .MAP_W(MAP_W), .MAX_BITS(MAX_BITS)
    ) u_build (
        .clk(clk), .rst_n(rst_n), .load_now(start_evt), .slot_map(slot_map),
        .drive_leds(drive_leds), .frame_q(frame_q)
    );

    ledlink_pins #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .en(link_en), .active(active), .clk_hi(clk_hi),
        .half_flip(half_flip), .frame_q(frame_q), .idx(idx),
        .inv_sclk(inv_sclk), .inv_load(inv_load), .inv_dout(inv_dout),
        .load_late(load_late), .dout_late(dout_late),
        .ser_clk(ser_clk), .ser_load(ser_load), .ser_dout(ser_dout)
    );

    ledlink_rx #(.RX_W(RX_W), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .active(active), .phase_first(phase_first),
        .clk_hi(clk_hi), .din_early(din_early), .idx(idx), .sd_in(sd_in),
        .frame_last(frame_last), .rx_bits(rx_bits)
    );

    assign frame_start = frame_begin;
    assign frame_end   = frame_last;
endmodule

// File: tb/sim_ledlink_tx.sv
`timescale 1ns/1ps
module sim_ledlink_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_en = 1'b0;
    logic [19:0] clk_div = '0;
    logic [5:0]  frame_len_m1 = '0;
    logic        inv_sclk = 0, inv_load = 0, inv_dout = 0;
    logic        load_late = 0, dout_late = 0, din_early = 0;
    logic [31:0] slot_map = '0;
    logic [23:0] drive_leds = '0;
    logic        sd_in = 1'b0;
    logic        ser_clk, ser_load, ser_dout, frame_start, frame_end;
    logic [11:0] rx_bits;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    ledlink_tx u0 (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .clk_div(clk_div),
        .frame_len_m1(frame_len_m1), .inv_sclk(inv_sclk), .inv_load(inv_load),
        .inv_dout(inv_dout), .load_late(load_late), .dout_late(dout_late),
        .din_early(din_early), .slot_map(slot_map), .drive_leds(drive_leds),
        .sd_in(sd_in), .ser_clk(ser_clk), .ser_load(ser_load), .ser_dout(ser_dout),
        .frame_start(frame_start), .frame_end(frame_end), .rx_bits(rx_bits)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] mp, input logic [23:0] ld);
        logic [63:0] f = '0;
        for (int s = 0; s < 4; s++) begin
            int d = int'(mp[s*8 +: 8]);
            for (int j = 0; j < 3; j++)
                f[3*s+j] = (d < 8) ? ld[3*d+j] : 1'b0;
        end
        return f;
    endfunction

    task automatic run_case(input int dv, input int ln, input bit ic, input bit il,
                            input bit id, input bit lf, input bit df, input bit de,
                            input logic [31:0] mp, input logic [23:0] ld,
                            input logic [15:0] pat, input int nfr);
        int p, fl, c, f, k;
        bit h, e_clk, e_ld, e_do;
        logic [63:0] fr;
        logic [11:0] e_rx;
        @(negedge clk);
        link_en = 0; clk_div = 20'(dv); frame_len_m1 = 6'(ln);
        inv_sclk = ic; inv_load = il; inv_dout = id;
        load_late = lf; dout_late = df; din_early = de;
        slot_map = mp; drive_leds = ld; sd_in = 0;
        repeat (3) @(negedge clk);
        // R6 R7: disabled lines sit at the inverted-inactive level
        chk("R6 R7 clk off", ser_clk, ic);
        chk("R6 R7 load off", ser_load, il);
        chk("R6 R7 dout off", ser_dout, id);
        chk("R6 R11 no pulses", {frame_start, frame_end}, 2'b00);
        link_en = 1;
        fr = exp_frame(mp, ld);
        p  = dv + 1;
        fl = (ln + 1) * 2 * p;
        e_rx = '0;
        for (int i = 0; i < 12; i++) if (i <= ln) e_rx[i] = pat[i];
        for (int t = 0; t <= nfr * fl; t++) begin
            @(negedge clk);
            c = t % fl; f = t / fl; k = c / (2 * p);
            h = (c % (2 * p)) < p;
            sd_in = (k < 16) ? pat[k] : 1'b0;
            e_clk = h;
            if (!lf || !h) e_ld = (k == 0);
            else if (k > 0) e_ld = (k - 1 == 0);
            else e_ld = (f > 0) && (ln == 0);
            if (!df || !h) e_do = fr[k];
            else if (k > 0) e_do = fr[k-1];
            else e_do = (f > 0) ? fr[ln] : 1'b0;
            // R4 R7
            chk("R4 R7 ser_clk", ser_clk, e_clk ^ ic);
            // R5 R7 R8
            chk("R5 R7 R8 ser_load", ser_load, e_ld ^ il);
            // R1 R2 R3 R7 R8
            chk("R1 R2 R3 R7 R8 ser_dout", ser_dout, e_do ^ id);
            // R11
            chk("R11 frame_start", frame_start, c == 0);
            chk("R11 frame_end", frame_end, c == fl - 1);
            // R9 R10
            if (c == 0 && f >= 1) chk("R9 R10 rx_bits", rx_bits, e_rx);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R12
        chk("R12 reset lines", {ser_clk, ser_load, ser_dout}, 3'b000);
        chk("R12 reset pulses", {frame_start, frame_end}, 2'b00);
        chk("R12 reset rx", rx_bits, 12'h000);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run_case(1, 11, 0, 0, 0, 0, 0, 0, 32'h03020100, 24'h5A3C96, 16'h0B6D, 3);
        // divider 0 with low-half sampling: last sample meets rx update (R9 R10)
        run_case(0, 11, 1, 1, 1, 1, 1, 0, 32'h00050207, 24'hC71E48, 16'h8A53, 3);
        run_case(2, 5, 0, 1, 0, 0, 1, 1, 32'h01030309, 24'hFFF00F, 16'h002D, 3);
        run_case(0, 15, 0, 0, 0, 1, 0, 1, 32'h04060301, 24'h6B2D91, 16'hF00F, 2);
        run_case(1, 0, 1, 0, 0, 1, 1, 0, 32'h00000002, 24'h0001C0, 16'h0001, 4);
        @(negedge clk);
        link_en = 0;
        repeat (2) @(negedge clk);
        chk("R6 final off", {ser_clk, ser_load, ser_dout}, 3'b100);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule